// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the processor reset for a supervised system. Its inputs are a digital low-supply flag, which an external comparator raises while the supply sits below its trip point, and an active-low manual-reset pin that may be wired to a push switch to ground. Reset stays asserted for as long as either source is active. When the last active source goes away, reset is stretched by a fixed hold interval. The hold is counted in system clock cycles, and its default corresponds to 200 ms at 50 MHz.

Both inputs pass through a two-flop synchronizer. The manual-reset input is also debounced against a prescaled timebase: a new level is accepted only after it has stayed the same for a set number of timebase ticks. Any fresh trigger while the hold runs reloads the full interval. The block drives an active-low and an active-high reset from one generator. Two parameters enable each polarity, and an output that is disabled sits at its inactive level. Reset is asserted from the block's own power-on state.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, reset is asserted. After `por_n` rises with no source active, reset stays asserted for HOLD_CYCLES+1 clock edges and releases on edge HOLD_CYCLES+2.
- R2: Reset is asserted from the third rising edge after `supply_low` goes high and stays asserted for as long as the flag is high.
- R3: After `supply_low` falls, reset is still asserted after HOLD_CYCLES+1 rising edges and is released after HOLD_CYCLES+2 rising edges.
- R4: A fresh trigger during the hold interval reloads the full interval, so the release is timed from the end of the last trigger.
- R5: A low level on `mr_n` that stays stable for at least DEB_TICKS timebase ticks asserts reset. Reset then stays asserted while `mr_n` is low.
- R6: When the debounced `mr_n` returns high, a fresh full hold interval starts before reset releases.
- R7: A low pulse or bounce on `mr_n` shorter than DEB_TICKS-1 ticks (one tick is TICK_DIV clock cycles) has no effect on the reset outputs.
- R8: When both polarities are enabled, `rst_out` is always the exact inverse of `rst_n_out`.
- R9: With EN_LOW=0, `rst_n_out` is held at 1. With EN_HIGH=0, `rst_out` is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| supply_low | input | 1 | Low-supply flag from the external comparator, active high |
| mr_n | input | 1 | Manual reset request, active low, may bounce |
| rst_n_out | output | 1 | Processor reset, active low |
| rst_out | output | 1 | Processor reset, active high |

## Verification
The bench times the release after a supply recovery to the exact edge, so a hold counter that is off by one, or one that skips the synchronizer delay, shows up as an early or late release. It retriggers the supply flag in the middle of a hold. A design that only set the counter when it was zero would release about half an interval too early. Short glitches and a bouncing train on the manual input are applied and every cycle is watched, which catches a debouncer that accepts the first sampled edge. Two further instances with one polarity disabled confirm that the disabled output never moves. A design that gated the wrong output would show an active level there.

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned HOLD_CYCLES = 10_000_000,
  parameter int unsigned TICK_DIV    = 50_000,
  parameter int unsigned DEB_TICKS   = 20,
  parameter bit          EN_LOW      = 1'b1,
  parameter bit          EN_HIGH     = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic mr_n,
  output logic rst_n_out,
  output logic rst_out
);

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned DW = (DEB_TICKS > 1) ? $clog2(DEB_TICKS) : 1;

  logic          sl_s1, sl_s2, mr_s1, mr_s2, mr_db;
  logic [TW-1:0] tick_cnt;
  logic [DW-1:0] deb_cnt;
  logic [HW-1:0] hold_cnt;
  logic          tick, trig, rst_act;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sl_s1 <= 1'b1; sl_s2 <= 1'b1;
      mr_s1 <= 1'b1; mr_s2 <= 1'b1;
    end else begin
      sl_s1 <= supply_low; sl_s2 <= sl_s1;
      mr_s1 <= mr_n;       mr_s2 <= mr_s1;
    end

  assign tick = (tick_cnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)    tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      mr_db   <= 1'b1;
      deb_cnt <= '0;
    end else if (mr_s2 == mr_db) begin
      deb_cnt <= '0;
    end else if (tick) begin
      if (deb_cnt == DW'(DEB_TICKS - 1)) begin
        mr_db   <= mr_s2;
        deb_cnt <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end

  assign trig = sl_s2 | ~mr_db;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                hold_cnt <= HW'(HOLD_CYCLES);
    else if (trig)             hold_cnt <= HW'(HOLD_CYCLES);
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;

  assign rst_act   = (hold_cnt != '0);
  assign rst_n_out = EN_LOW  ? ~rst_act : 1'b1;
  assign rst_out   = EN_HIGH ?  rst_act : 1'b0;

  a_r2_supply_asserts: assert property (@(posedge clk) disable iff (!por_n)
    sl_s2 |=> rst_act);

  a_r5_manual_asserts: assert property (@(posedge clk) disable iff (!por_n)
    !mr_db |=> rst_act);

  a_r3_release_quiet: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_act) |-> !$past(trig));

  a_r4_count_down: assert property (@(posedge clk) disable iff (!por_n)
    (!trig && rst_act) |=> (hold_cnt == $past(hold_cnt) - 1'b1));

  a_r7_accept_on_tick: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(mr_db) |-> $past(tick));

endmodule

// File: tb/sup_reset_gen_bench.sv
module sup_reset_gen_bench;
  localparam int unsigned HOLD = 40;
  localparam int unsigned TDIV = 4;
  localparam int unsigned DEB  = 3;

  logic clk = 1'b0, por_n = 1'b0, supply_low = 1'b0, mr_n = 1'b1;
  logic rn, rh, lo_rn, lo_rh, hi_rn, hi_rh;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  sup_reset_gen #(.HOLD_CYCLES(HOLD), .TICK_DIV(TDIV), .DEB_TICKS(DEB)) u_sup_reset_gen (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .mr_n(mr_n),
    .rst_n_out(rn), .rst_out(rh));
  sup_reset_gen #(.HOLD_CYCLES(HOLD), .TICK_DIV(TDIV), .DEB_TICKS(DEB), .EN_HIGH(1'b0)) u_sup_reset_gen_lo (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .mr_n(mr_n),
    .rst_n_out(lo_rn), .rst_out(lo_rh));
  sup_reset_gen #(.HOLD_CYCLES(HOLD), .TICK_DIV(TDIV), .DEB_TICKS(DEB), .EN_LOW(1'b0)) u_sup_reset_gen_hi (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .mr_n(mr_n),
    .rst_n_out(hi_rn), .rst_out(hi_rh));

  // [31] supply_low, [30] mr_n, [29] expected reset active, [27:24] requirement, [15:0] edges to wait
  localparam int NV = 11;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 8'd0, 16'd2},   // R2 not yet after two edges
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 8'd0, 16'd1},   // R2 asserted on third edge
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 8'd0, 16'd50},  // R2 held while low
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'd0, 16'd41},  // R3 last held edge
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 8'd0, 16'd1},   // R3 released
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 8'd0, 16'd3},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 8'd0, 16'd20},  // mid hold
    {1'b1, 1'b1, 1'b1, 1'b0, 4'd4, 8'd0, 16'd1},   // R4 retrigger pulse
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd4, 8'd0, 16'd41},  // R4 full reload
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd4, 8'd0, 16'd1},
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 8'd0, 16'd5}    // R3 stays released
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_rst(input string req, input bit exp);
    chk(rh == exp, req, "rst_out", int'(rh), int'(exp));
    chk(rn == !exp, req, "rst_n_out", int'(rn), int'(!exp));
    chk(rh == !rn, "R8", "inverse", int'(rh), int'(!rn));
    chk(lo_rh == 1'b0 && lo_rn == !exp, "R9", "low-only outputs", int'({lo_rn, lo_rh}), int'({!exp, 1'b0}));
    chk(hi_rn == 1'b1 && hi_rh == exp, "R9", "high-only outputs", int'({hi_rn, hi_rh}), int'({1'b1, exp}));
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch_quiet(input string req, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rh !== 1'b0 || rn !== 1'b1) bad++;
    end
    chk(bad == 0, req, "cycles with reset active", bad, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_edges(3);
    check_rst("R1", 1'b1);                     // R1 during power-on reset
    por_n = 1'b1;
    wait_edges(HOLD + 1);
    check_rst("R1", 1'b1);
    wait_edges(1);
    check_rst("R1", 1'b0);

    for (int i = 0; i < NV; i++) begin
      supply_low = VEC[i][31];
      mr_n       = VEC[i][30];
      wait_edges(int'(VEC[i][15:0]));
      check_rst($sformatf("R%0d", VEC[i][27:24]), VEC[i][29]);
    end

    // R5 held manual reset asserts and stays asserted
    mr_n = 1'b0;
    wait_edges(20);
    check_rst("R5", 1'b1);
    wait_edges(30);
    check_rst("R5", 1'b1);
    // R6 release starts a full hold
    mr_n = 1'b1;
    wait_edges(HOLD);
    check_rst("R6", 1'b1);
    wait_edges(20);
    check_rst("R6", 1'b0);

    // R7 short glitch ignored
    mr_n = 1'b0;
    wait_edges(5);
    mr_n = 1'b1;
    watch_quiet("R7", 40);

    // R7 bouncing train ignored
    for (int j = 0; j < 8; j++) begin
      mr_n = ~mr_n;
      wait_edges(3);
    end
    mr_n = 1'b1;
    watch_quiet("R7", 40);
    check_rst("R7", 1'b0);

    finish_run();
  end
endmodule